// File: doc/BRIEF.md
# Mode-Register Initialisation Sequencer

This block drives the mode-register bring-up of an LPDDR memory device, for one rank or for two. A single start pulse launches a fixed program. The block first waits out the 200 µs power-up interval that must follow the raising of the clock enable. It then walks through six mode-register writes for rank 0, in this order: device reset (MR63), ZQ initialisation (MR10), output drive strength (MR3), MR1, MR2, and the ODT setting (MR11). For each write it places a command word on `mrs_cmd`, raises `mrs_strobe`, holds the strobe for the required settling time, drops it for one cycle, and then moves on. If the dual-rank flag was set when the sequence started, the same six writes are then repeated for rank 1. A one-cycle `init_done` pulse closes the sequence.

All waits are counted in clock cycles. They come from a cycles-per-microsecond value that is captured at start. The controller logic that encodes the command on the memory bus lies outside this block. It reads `mrs_cmd` while the strobe is high. The six mode-register values are configuration inputs and must be held steady while a sequence runs.

The controller has five states. `ST_IDLE` moves to `ST_PWR_WAIT` on start. `ST_PWR_WAIT` moves to `ST_ISSUE` (rank 0, step 0) when its timer expires. `ST_ISSUE` moves to `ST_GAP` when its timer expires. `ST_GAP` takes one of three paths: it moves to `ST_ISSUE` for the next step; it moves to `ST_ISSUE` for rank 1, step 0, after the last step of rank 0 when dual rank is set; otherwise it moves to `ST_DONE` after the last step. `ST_DONE` always moves back to `ST_IDLE`.

Top module: `mrs_init_seq`

## Requirements
- R1: After reset, `mrs_strobe`, `init_done` and `mrs_cmd` are all 0.
- R2: A start pulse sampled in idle begins the sequence. The first strobe rises after exactly 200·C cycles with the strobe low, counted from the clock edge that sampled start. C is the captured cycles-per-microsecond value.
- R3: The command word is `{rank, value}`. The rank number (0 or 1) sits in bits 31:28 and the mode-register value in bits 27:0. Per rank the values are issued in the order reset, ZQ init, drive strength, MR1, MR2, ODT.
- R4: The strobe stays high for exactly 10·C cycles for the reset command and for exactly C cycles for each of the other five commands.
- R5: `mrs_cmd` is constant while the strobe is high and through the single low cycle that follows it. Between two consecutive commands the strobe is low for exactly one cycle.
- R6: With the dual-rank flag clear at start, exactly six commands are issued, all for rank 0. With the flag set, the six rank-1 commands follow the six rank-0 commands.
- R7: A cycles-per-microsecond value of 0 is treated as 1.
- R8: A start pulse that arrives while a sequence is running has no effect: the running sequence is not restarted and no second sequence follows it.
- R9: `init_done` is high for exactly one cycle. That cycle is the second cycle after the last high cycle of the final strobe, and the strobe is low during it.
- R10: The cycles-per-microsecond value and the dual-rank flag are captured at start. Changing them during a sequence does not alter its timing or its rank count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; ignored unless idle |
| dual_rank | input | 1 | Also initialise rank 1 |
| cyc_per_us | input | CPU_W (8) | Clock cycles per microsecond; 0 is treated as 1 |
| mr_reset | input | MR_W (28) | Value for the device-reset write |
| mr_zq | input | MR_W (28) | Value for the ZQ-init write |
| mr_drive | input | MR_W (28) | Value for the drive-strength write |
| mr_one | input | MR_W (28) | Value for the MR1 write |
| mr_two | input | MR_W (28) | Value for the MR2 write |
| mr_odt | input | MR_W (28) | Value for the ODT write |
| mrs_cmd | output | MR_W+RANK_W (32) | Command word `{rank, value}` |
| mrs_strobe | output | 1 | Command strobe |
| init_done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: a 200 µs power-up wait, a 10 µs reset wait, a 1 µs wait for the other writes, and 28-bit mode values. It drives a cycles-per-microsecond value between 0 and 4. A full dual-rank sequence therefore fits in about a thousand cycles, so many random runs become affordable. Each run checks the exact power-up length, every strobe width and gap, and the position of the done pulse. The value 0 exercises the clamp to one cycle per microsecond. Runs that poke start, the rate and the rank flag in mid-sequence exercise the capture-at-start behaviour.

// File: rtl/mrs_init_pkg.sv
package mrs_init_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PWR_WAIT,
        ST_ISSUE,
        ST_GAP,
        ST_DONE
    } seq_state_t;

    localparam int unsigned NUM_STEPS = 6;
    localparam int unsigned STEP_W    = 3;

endpackage

// File: rtl/mrs_wait_timer.sv
module mrs_wait_timer #(
    parameter int unsigned CPU_W = 8,
    parameter int unsigned US_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [US_W-1:0]  us_target,
    input  logic [CPU_W-1:0] cyc_per_us,
    output logic             expire
);

    logic [CPU_W-1:0] cyc_cnt;
    logic [US_W-1:0]  us_cnt;
    logic             running;
    logic [CPU_W-1:0] cyc_reload;
    logic [US_W-1:0]  us_reload;

    // a rate of 0 behaves as 1 cycle per microsecond
    assign cyc_reload = (cyc_per_us == '0) ? '0 : cyc_per_us - 1'b1;
    assign us_reload  = (us_target  == '0) ? '0 : us_target  - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_cnt <= '0;
            us_cnt  <= '0;
            running <= 1'b0;
        end else if (load) begin
            cyc_cnt <= cyc_reload;
            us_cnt  <= us_reload;
            running <= 1'b1;
        end else if (running) begin
            if (cyc_cnt == '0) begin
                if (us_cnt == '0) begin
                    running <= 1'b0;
                end else begin
                    us_cnt  <= us_cnt - 1'b1;
                    cyc_cnt <= cyc_reload;
                end
            end else begin
                cyc_cnt <= cyc_cnt - 1'b1;
            end
        end
    end

    assign expire = running && (cyc_cnt == '0) && (us_cnt == '0);

    // R7/R10: while a wait runs, the cycle count never exceeds the clamped rate
    a_r7_cycle_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cyc_cnt <= cyc_reload));

endmodule

// File: rtl/mrs_step_sel.sv
module mrs_step_sel
    import mrs_init_pkg::*;
#(
    parameter int unsigned MR_W = 28
) (
    input  logic [STEP_W-1:0] step,
    input  logic [MR_W-1:0]   mr_reset,
    input  logic [MR_W-1:0]   mr_zq,
    input  logic [MR_W-1:0]   mr_drive,
    input  logic [MR_W-1:0]   mr_one,
    input  logic [MR_W-1:0]   mr_two,
    input  logic [MR_W-1:0]   mr_odt,
    output logic [MR_W-1:0]   mr_val
);

    // step index fixes the issue order within a rank
    always_comb begin
        unique case (step)
            3'd0:    mr_val = mr_reset;
            3'd1:    mr_val = mr_zq;
            3'd2:    mr_val = mr_drive;
            3'd3:    mr_val = mr_one;
            3'd4:    mr_val = mr_two;
            3'd5:    mr_val = mr_odt;
            default: mr_val = '0;
        endcase
    end

endmodule

// File: rtl/mrs_init_seq.sv
module mrs_init_seq
    import mrs_init_pkg::*;
#(
    parameter int unsigned MR_W       = 28,
    parameter int unsigned RANK_W     = 4,
    parameter int unsigned CPU_W      = 8,
    parameter int unsigned US_W       = 8,
    parameter int unsigned POWERUP_US = 200,
    parameter int unsigned LONG_US    = 10,
    parameter int unsigned SHORT_US   = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   dual_rank,
    input  logic [CPU_W-1:0]       cyc_per_us,
    input  logic [MR_W-1:0]        mr_reset,
    input  logic [MR_W-1:0]        mr_zq,
    input  logic [MR_W-1:0]        mr_drive,
    input  logic [MR_W-1:0]        mr_one,
    input  logic [MR_W-1:0]        mr_two,
    input  logic [MR_W-1:0]        mr_odt,
    output logic [MR_W+RANK_W-1:0] mrs_cmd,
    output logic                   mrs_strobe,
    output logic                   init_done
);

    localparam int unsigned CMD_W = MR_W + RANK_W;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    seq_state_t        state, state_n;
    logic [STEP_W-1:0] step, step_n;
    logic              rank, rank_n;
    logic              dual_q;
    logic [CPU_W-1:0]  cpu_q;

    logic              tmr_load;
    logic [US_W-1:0]   tmr_us;
    logic [CPU_W-1:0]  tmr_cpu;
    logic              tmr_expire;
    logic [MR_W-1:0]   mr_val;

    // in idle the timer sees the live rate so the first wait uses the value captured now
    assign tmr_cpu = (state == ST_IDLE) ? cyc_per_us : cpu_q;

    mrs_wait_timer #(
        .CPU_W (CPU_W),
        .US_W  (US_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (tmr_load),
        .us_target  (tmr_us),
        .cyc_per_us (tmr_cpu),
        .expire     (tmr_expire)
    );

    mrs_step_sel #(
        .MR_W (MR_W)
    ) u_sel (
        .step     (step),
        .mr_reset (mr_reset),
        .mr_zq    (mr_zq),
        .mr_drive (mr_drive),
        .mr_one   (mr_one),
        .mr_two   (mr_two),
        .mr_odt   (mr_odt),
        .mr_val   (mr_val)
    );

    // next-state and timer control
    always_comb begin
        state_n  = state;
        step_n   = step;
        rank_n   = rank;
        tmr_load = 1'b0;
        tmr_us   = US_W'(SHORT_US);
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_n  = ST_PWR_WAIT;
                    tmr_load = 1'b1;
                    tmr_us   = US_W'(POWERUP_US);
                end
            end
            ST_PWR_WAIT: begin
                if (tmr_expire) begin
                    state_n  = ST_ISSUE;
                    step_n   = '0;
                    rank_n   = 1'b0;
                    tmr_load = 1'b1;
                    tmr_us   = US_W'(LONG_US);
                end
            end
            ST_ISSUE: begin
                if (tmr_expire) begin
                    state_n = ST_GAP;
                end
            end
            ST_GAP: begin
                if (step != LAST_STEP) begin
                    state_n  = ST_ISSUE;
                    step_n   = step + 1'b1;
                    tmr_load = 1'b1;
                    tmr_us   = US_W'(SHORT_US);
                end else if (!rank && dual_q) begin
                    state_n  = ST_ISSUE;
                    step_n   = '0;
                    rank_n   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_us   = US_W'(LONG_US);
                end else begin
                    state_n = ST_DONE;
                end
            end
            ST_DONE: begin
                state_n = ST_IDLE;
            end
            default: begin
                state_n = ST_IDLE;
            end
        endcase
    end

    // state register with start-time capture of rate and rank count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            step   <= '0;
            rank   <= 1'b0;
            dual_q <= 1'b0;
            cpu_q  <= '0;
        end else begin
            state <= state_n;
            step  <= step_n;
            rank  <= rank_n;
            if (state == ST_IDLE && start) begin
                dual_q <= dual_rank;
                cpu_q  <= cyc_per_us;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        mrs_strobe = (state == ST_ISSUE);
        init_done  = (state == ST_DONE);
        if (state == ST_ISSUE || state == ST_GAP) begin
            mrs_cmd = {{(RANK_W-1){1'b0}}, rank, mr_val};
        end else begin
            mrs_cmd = '0;
        end
    end

    // R3: rank field carries only rank 0 or rank 1
    a_r3_rank_field: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_cmd[CMD_W-1:MR_W] <= RANK_W'(1));

    // R5: command word held steady across a strobe
    a_r5_cmd_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_strobe && $past(mrs_strobe)) |-> $stable(mrs_cmd));

    // R5/R9: a single low cycle after each strobe, then next strobe or done
    a_r5_single_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mrs_strobe) |=> (mrs_strobe || init_done));

    // R6: rank 1 commands only when dual rank was captured
    a_r6_rank1_needs_dual: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_strobe && mrs_cmd[MR_W]) |-> dual_q);

    // R9: done lasts one cycle and never overlaps the strobe
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> !init_done);
    a_r9_done_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(init_done && mrs_strobe));

    // R8: a busy start never re-enters the power-up wait
    a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && state != ST_PWR_WAIT && start) |=> (state != ST_PWR_WAIT));

    // R10: captured rate holds for the whole sequence
    a_r10_rate_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(cpu_q));

endmodule

// File: tb/mrs_init_seq_bench.sv
module mrs_init_seq_bench;

    localparam int unsigned MR_W  = 28;
    localparam int unsigned CMD_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             dual_rank = 1'b0;
    logic [7:0]       cyc_per_us = 8'd1;
    logic [MR_W-1:0]  mrv [6];
    logic [CMD_W-1:0] mrs_cmd;
    logic             mrs_strobe;
    logic             init_done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    mrs_init_seq u_mrs_init_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .dual_rank  (dual_rank),
        .cyc_per_us (cyc_per_us),
        .mr_reset   (mrv[0]),
        .mr_zq      (mrv[1]),
        .mr_drive   (mrv[2]),
        .mr_one     (mrv[3]),
        .mr_two     (mrv[4]),
        .mr_odt     (mrv[5]),
        .mrs_cmd    (mrs_cmd),
        .mrs_strobe (mrs_strobe),
        .init_done  (init_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [CMD_W-1:0] exp_cmd(input int rk, input int st);
        return {4'(rk), mrv[st]};
    endfunction

    function automatic int exp_high(input int ce, input int st);
        return (st == 0) ? 10 * ce : ce;
    endfunction

    task automatic run_seq(input int c, input bit dual, input bit poke);
        int ce, n, cnt, hi, rk, st;
        bit stable;
        logic [CMD_W-1:0] cmd0;
        string rq;
        ce = (c == 0) ? 1 : c;
        for (int k = 0; k < 6; k++) mrv[k] = MR_W'($urandom);
        cyc_per_us = 8'(c);
        dual_rank  = dual;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        while (!mrs_strobe && cnt < 5000) begin
            cnt++;
            if (poke && cnt == 3) begin
                start = 1'b1;
                cyc_per_us = 8'(c + 3);
                dual_rank = !dual;
            end else if (poke && cnt == 4) begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        rq = (c == 0) ? "R7" : (poke ? "R10" : "R2");
        check(cnt == 200 * ce, rq, "power-up low cycles", cnt, 200 * ce);
        n = dual ? 12 : 6;
        for (int i = 0; i < n; i++) begin
            rk = i / 6;
            st = i % 6;
            cmd0 = mrs_cmd;
            check(cmd0 == exp_cmd(rk, st), (rk == 1) ? "R6" : "R3", "command word",
                  cmd0, exp_cmd(rk, st));
            hi = 0;
            stable = 1;
            while (mrs_strobe && hi < 5000) begin
                if (mrs_cmd != cmd0) stable = 0;
                hi++;
                @(negedge clk);
            end
            check(hi == exp_high(ce, st), poke ? "R10" : "R4", "strobe width",
                  hi, exp_high(ce, st));
            check(stable && mrs_cmd == cmd0 && !init_done, "R5", "cmd held into gap",
                  mrs_cmd, cmd0);
            @(negedge clk);
            if (i < n - 1) begin
                check(mrs_strobe && !init_done, "R5", "single-cycle gap", mrs_strobe, 1);
            end else begin
                check(init_done && !mrs_strobe, dual ? "R9" : "R6", "done after last gap",
                      init_done, 1);
            end
        end
        @(negedge clk);
        check(!init_done, "R9", "done width one", init_done, 0);
        cnt = 0;
        for (int j = 0; j < 40; j++) begin
            if (mrs_strobe || init_done || mrs_cmd != '0) cnt++;
            @(negedge clk);
        end
        check(cnt == 0, poke ? "R8" : "R6", "quiet after done", cnt, 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_0a17));
        for (int k = 0; k < 6; k++) mrv[k] = '0;
        repeat (3) @(negedge clk);
        check(mrs_strobe == 0 && init_done == 0 && mrs_cmd == '0, "R1", "reset outputs",
              {mrs_strobe, init_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mrs_strobe == 0 && init_done == 0 && mrs_cmd == '0, "R1", "idle outputs",
              mrs_cmd, 0);
        run_seq(1, 1'b0, 1'b0);
        run_seq(0, 1'b1, 1'b0);
        run_seq(2, 1'b1, 1'b1);
        run_seq(4, 1'b0, 1'b1);
        run_seq(3, 1'b1, 1'b0);
        for (int r = 0; r < 8; r++) begin
            run_seq(int'($urandom_range(0, 4)), 1'($urandom), 1'($urandom));
        end
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule